// File: doc/BRIEF.md
# UART Boot Command Engine

This block is a hardware command interpreter placed behind a byte-wide UART receive and transmit path. Before the processor starts, a host uses it to fill instruction memory, write and read data memory, and finally start execution at a chosen address. After reset the engine stays asleep until a wake-up byte arrives. It then decodes single-character commands, each followed by one or two 32-bit operands, and answers each with a one-character acknowledgement.

Operands always arrive most-significant byte first. Data read back from data memory is returned least-significant byte first. The two write commands echo their own letter before taking operands. The read command sends no echo. The jump command produces a one-cycle request carrying the target address, sends no reply, and puts the engine back to sleep. Both byte streams use a valid/ready handshake. Memory writes are one-cycle strobes. A data read takes its data one cycle after the read strobe.

Top module: `boot_cmd_engine`

## Requirements
- R1: After reset every received byte other than 0x48 is consumed and ignored. A 0x48 is answered with 0x4F and switches the engine to command mode.
- R2: In command mode, 0x57 is echoed as 0x57. Two operands follow: an address, then an instruction word. The engine pulses `imem_we` for one cycle with `imem_addr`/`imem_wdata` set to those operands, then replies 0x44.
- R3: In command mode, 0x51 is echoed as 0x51. Two operands follow: an address, then a data word. The engine pulses `dmem_we` for one cycle with `dmem_addr`/`dmem_wdata` set to those operands, then replies 0x41.
- R4: In command mode, 0x54 is followed by one address operand and sends no echo. The engine replies 0x47, pulses `dmem_re` for one cycle with `dmem_addr` set to the address, and samples `dmem_rdata` on the following cycle. It then sends the four bytes of the read word, bits 7:0 first and bits 31:24 last.
- R5: Each 32-bit operand is four received bytes. The first byte received becomes bits 31:24 and the fourth becomes bits 7:0.
- R6: In command mode, 0x4A is followed by one address operand. The engine then raises `jump_req` for exactly one cycle with `jump_target` equal to the address. It transmits nothing for this command and returns to the sleeping state of R1.
- R7: In command mode, 0x48 and any byte other than 0x57, 0x51, 0x54 and 0x4A are answered with 0x4F, and the engine stays in command mode.
- R8: Once `tx_valid` rises, `tx_data` and `tx_valid` hold until a cycle in which `tx_ready` is high.
- R9: `rx_ready` is high only while the engine waits for the wake-up byte, a command byte or an operand byte. It is never high while a byte is being transmitted. An incomplete operand waits indefinitely.
- R10: During and right after reset, `tx_valid`, `imem_we`, `dmem_we`, `dmem_re` and `jump_req` are low, and `rx_ready` is high.
- R11: The write strobes are each one cycle long and are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Engine takes the byte this cycle |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_addr | output | 32 | Instruction memory address |
| imem_wdata | output | 32 | Instruction word to write |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_re | output | 1 | Data memory read strobe |
| dmem_addr | output | 32 | Data memory address |
| dmem_wdata | output | 32 | Data word to write |
| dmem_rdata | input | 32 | Read data, valid the cycle after `dmem_re` |
| jump_req | output | 1 | One-cycle start request |
| jump_target | output | 32 | Start address carried with `jump_req` |

## Verification
The assertions assume that the transmitter obeys the handshake and eventually raises `tx_ready`. They also assume that data memory returns its word exactly one cycle after the read strobe and that the host never withdraws a byte before it is taken. The bench keeps to these assumptions. Its host task holds `rx_valid` and the byte until `rx_ready` is seen. Its memory model registers read data on the edge that ends the read strobe. Its transmit-ready pattern stalls for some cycles but never stays low for good.

// File: rtl/bce_pkg.sv
// Package: shared state and opcode types plus character codes of the boot
// command engine. Assumes 8-bit characters on both byte streams.
package bce_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_WAKE,
        ST_CMD,
        ST_SEND,
        ST_ADDR,
        ST_DATA,
        ST_WRITE,
        ST_READ,
        ST_READ_WAIT,
        ST_SEND_WORD,
        ST_JUMP
    } state_e;

    typedef enum logic [1:0] {
        OP_IWR,
        OP_DWR,
        OP_DRD,
        OP_JMP
    } op_e;

    localparam logic [7:0] CH_WAKE  = 8'h48;
    localparam logic [7:0] CH_ACK   = 8'h4F;
    localparam logic [7:0] CH_IWR   = 8'h57;
    localparam logic [7:0] CH_IDONE = 8'h44;
    localparam logic [7:0] CH_DWR   = 8'h51;
    localparam logic [7:0] CH_DDONE = 8'h41;
    localparam logic [7:0] CH_DRD   = 8'h54;
    localparam logic [7:0] CH_DRESP = 8'h47;
    localparam logic [7:0] CH_JMP   = 8'h4A;
endpackage

// File: rtl/bce_operand_shift.sv
// Module: builds one operand from WORD_BYTES received bytes, first byte in the
// most significant position. Assumes shift_en is asserted only for bytes that
// belong to an operand. word_next is the operand value including the byte
// currently offered, so the caller can capture the complete operand in the
// same cycle that its last byte is taken.
module bce_operand_shift #(
    parameter int WORD_BYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         shift_en,
    input  logic [7:0]                   byte_in,
    output logic [WORD_BYTES*8-1:0]      word_next,
    output logic                         last_byte
);
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int CNT_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;

    // Combine the bytes collected so far with the incoming byte.
    always_comb begin
        word_next = (word_q << 8) | WORD_W'(byte_in);
        last_byte = (cnt_q == CNT_W'(WORD_BYTES - 1));
    end

    // Shift register and byte counter; the counter wraps after each operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (shift_en) begin
            word_q <= word_next;
            cnt_q  <= last_byte ? '0 : cnt_q + 1'b1;
        end
    end

    AST_SHIFT_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_q[7:0] == $past(byte_in)))
        else $error("AST_SHIFT_LOW_BYTE"); // R5
    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && last_byte) |=> (cnt_q == '0))
        else $error("AST_COUNT_WRAP"); // R5
endmodule

// File: rtl/bce_tx_hold.sv
// Module: transmit holding register. It accepts a byte on load and presents
// it with tx_valid until the transmitter takes it. Assumes the controller
// loads only while the register is empty or in the cycle its byte is taken.
module bce_tx_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       done
);
    // A byte leaves in any cycle where valid meets ready.
    always_comb done = tx_valid && tx_ready;

    // Hold the byte until it is taken; a load in the same cycle refills it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (load) begin
            tx_valid <= 1'b1;
            tx_data  <= load_byte;
        end else if (done) begin
            tx_valid <= 1'b0;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
        else $error("AST_TX_HOLD"); // R8
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!tx_valid || tx_ready))
        else $error("AST_NO_OVERWRITE"); // R8
endmodule

// File: rtl/bce_controller.sv
// Module: command sequencer. It decodes the wake-up and command bytes, steers
// operand bytes into the shifter, drives the memory strobes and the jump
// pulse, and chooses the reply bytes. Assumes the operand shifter and the
// transmit holding register sit beside it. A read returns its data one cycle
// after dmem_re.
module bce_controller
    import bce_pkg::*;
#(
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              rx_data,
    input  logic                    rx_valid,
    output logic                    rx_ready,
    input  logic [WORD_BYTES*8-1:0] opnd_next,
    input  logic                    opnd_last,
    output logic                    opnd_shift,
    output logic                    tx_load,
    output logic [7:0]              tx_byte,
    input  logic                    tx_done,
    input  logic                    tx_busy,
    output logic                    imem_we,
    output logic                    dmem_we,
    output logic                    dmem_re,
    output logic [WORD_BYTES*8-1:0] addr,
    output logic [WORD_BYTES*8-1:0] wdata,
    input  logic [WORD_BYTES*8-1:0] dmem_rdata,
    output logic                    jump_req
);
    localparam int WORD_W = WORD_BYTES * 8;
    localparam int CNT_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam int SH_W   = CNT_W + 4;

    state_e            state_q, state_n;
    state_e            ret_q, ret_n;
    op_e               op_q, op_n;
    logic [WORD_W-1:0] addr_q, wdata_q, rd_q;
    logic [CNT_W-1:0]  idx_q;
    logic              rx_fire;
    logic              idx_last;
    logic [SH_W-1:0]   sh_amt;
    logic [WORD_W-1:0] rd_shift;

    // The engine takes input only while it waits for a wake, command or operand byte.
    always_comb begin
        rx_ready   = (state_q == ST_WAKE) || (state_q == ST_CMD) ||
                     (state_q == ST_ADDR) || (state_q == ST_DATA);
        rx_fire    = rx_valid && rx_ready;
        opnd_shift = rx_fire && ((state_q == ST_ADDR) || (state_q == ST_DATA));
    end

    // Select the next read-data byte, least significant first.
    always_comb begin
        idx_last = (idx_q == CNT_W'(WORD_BYTES - 1));
        sh_amt   = SH_W'({idx_q, 3'b000}) + SH_W'(8);
        rd_shift = rd_q >> sh_amt;
    end

    // Next-state decode and reply selection.
    always_comb begin
        state_n = state_q;
        ret_n   = ret_q;
        op_n    = op_q;
        tx_load = 1'b0;
        tx_byte = 8'h00;
        case (state_q)
            ST_WAKE: begin
                if (rx_fire && rx_data == CH_WAKE) begin
                    tx_load = 1'b1;
                    tx_byte = CH_ACK;
                    state_n = ST_SEND;
                    ret_n   = ST_CMD;
                end
            end
            ST_CMD: begin
                if (rx_fire) begin
                    case (rx_data)
                        CH_IWR: begin
                            op_n    = OP_IWR;
                            tx_load = 1'b1;
                            tx_byte = CH_IWR;
                            state_n = ST_SEND;
                            ret_n   = ST_ADDR;
                        end
                        CH_DWR: begin
                            op_n    = OP_DWR;
                            tx_load = 1'b1;
                            tx_byte = CH_DWR;
                            state_n = ST_SEND;
                            ret_n   = ST_ADDR;
                        end
                        CH_DRD: begin
                            op_n    = OP_DRD;
                            state_n = ST_ADDR;
                        end
                        CH_JMP: begin
                            op_n    = OP_JMP;
                            state_n = ST_ADDR;
                        end
                        default: begin
                            tx_load = 1'b1;
                            tx_byte = CH_ACK;
                            state_n = ST_SEND;
                            ret_n   = ST_CMD;
                        end
                    endcase
                end
            end
            ST_SEND: begin
                if (tx_done) state_n = ret_q;
            end
            ST_ADDR: begin
                if (rx_fire && opnd_last) begin
                    case (op_q)
                        OP_IWR, OP_DWR: state_n = ST_DATA;
                        OP_DRD: begin
                            tx_load = 1'b1;
                            tx_byte = CH_DRESP;
                            state_n = ST_SEND;
                            ret_n   = ST_READ;
                        end
                        default: state_n = ST_JUMP;
                    endcase
                end
            end
            ST_DATA: begin
                if (rx_fire && opnd_last) state_n = ST_WRITE;
            end
            ST_WRITE: begin
                tx_load = 1'b1;
                tx_byte = (op_q == OP_IWR) ? CH_IDONE : CH_DDONE;
                state_n = ST_SEND;
                ret_n   = ST_CMD;
            end
            ST_READ: state_n = ST_READ_WAIT;
            ST_READ_WAIT: begin
                tx_load = 1'b1;
                tx_byte = dmem_rdata[7:0];
                state_n = ST_SEND_WORD;
            end
            ST_SEND_WORD: begin
                if (tx_done) begin
                    if (idx_last) begin
                        state_n = ST_CMD;
                    end else begin
                        tx_load = 1'b1;
                        tx_byte = rd_shift[7:0];
                    end
                end
            end
            ST_JUMP: state_n = ST_WAKE;
            default: state_n = ST_WAKE;
        endcase
    end

    // State, return-state and opcode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAKE;
            ret_q   <= ST_WAKE;
            op_q    <= OP_IWR;
        end else begin
            state_q <= state_n;
            ret_q   <= ret_n;
            op_q    <= op_n;
        end
    end

    // Capture completed operands, read data and the transmit byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
            idx_q   <= '0;
        end else begin
            if (state_q == ST_ADDR && rx_fire && opnd_last) addr_q <= opnd_next;
            if (state_q == ST_DATA && rx_fire && opnd_last) wdata_q <= opnd_next;
            if (state_q == ST_READ_WAIT) begin
                rd_q  <= dmem_rdata;
                idx_q <= '0;
            end else if (state_q == ST_SEND_WORD && tx_done && !idx_last) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Strobes decoded from the state; address and data come from held registers.
    always_comb begin
        imem_we  = (state_q == ST_WRITE) && (op_q == OP_IWR);
        dmem_we  = (state_q == ST_WRITE) && (op_q == OP_DWR);
        dmem_re  = (state_q == ST_READ);
        jump_req = (state_q == ST_JUMP);
        addr     = addr_q;
        wdata    = wdata_q;
    end

    AST_IWE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        imem_we |=> !imem_we) else $error("AST_IWE_PULSE"); // R11
    AST_DWE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we) else $error("AST_DWE_PULSE"); // R11
    AST_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(imem_we && dmem_we)) else $error("AST_WE_EXCL"); // R11
    AST_JUMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |=> (!jump_req && rx_ready)) else $error("AST_JUMP_PULSE"); // R6
    AST_JUMP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |-> !tx_busy) else $error("AST_JUMP_SILENT"); // R6
    AST_NO_RX_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && tx_busy)) else $error("AST_NO_RX_WHILE_TX"); // R9
    AST_READ_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |=> (!dmem_re && !rx_ready && $stable(addr))) else $error("AST_READ_SAMPLE"); // R4
    AST_READ_REPLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmem_re) |-> !tx_busy) else $error("AST_READ_REPLY_FIRST"); // R4
endmodule

// File: rtl/boot_cmd_engine.sv
// Module: top of the UART boot command engine. It joins the command
// sequencer, the operand shifter and the transmit holding register, and
// fans the held address and data out to both memory ports. Assumes byte
// streams with valid/ready handshakes and a data memory with one cycle of
// read latency.
module boot_cmd_engine #(
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              rx_data,
    input  logic                    rx_valid,
    output logic                    rx_ready,
    output logic [7:0]              tx_data,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic                    imem_we,
    output logic [WORD_BYTES*8-1:0] imem_addr,
    output logic [WORD_BYTES*8-1:0] imem_wdata,
    output logic                    dmem_we,
    output logic                    dmem_re,
    output logic [WORD_BYTES*8-1:0] dmem_addr,
    output logic [WORD_BYTES*8-1:0] dmem_wdata,
    input  logic [WORD_BYTES*8-1:0] dmem_rdata,
    output logic                    jump_req,
    output logic [WORD_BYTES*8-1:0] jump_target
);
    localparam int WORD_W = WORD_BYTES * 8;

    logic [WORD_W-1:0] opnd_next;
    logic              opnd_last;
    logic              opnd_shift;
    logic              tx_load;
    logic [7:0]        tx_byte;
    logic              tx_done;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] wdata;

    bce_operand_shift #(.WORD_BYTES(WORD_BYTES)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (opnd_shift),
        .byte_in   (rx_data),
        .word_next (opnd_next),
        .last_byte (opnd_last)
    );

    bce_tx_hold u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_byte (tx_byte),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .done      (tx_done)
    );

    bce_controller #(.WORD_BYTES(WORD_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .opnd_next  (opnd_next),
        .opnd_last  (opnd_last),
        .opnd_shift (opnd_shift),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte),
        .tx_done    (tx_done),
        .tx_busy    (tx_valid),
        .imem_we    (imem_we),
        .dmem_we    (dmem_we),
        .dmem_re    (dmem_re),
        .addr       (addr),
        .wdata      (wdata),
        .dmem_rdata (dmem_rdata),
        .jump_req   (jump_req)
    );

    // Both memory ports and the jump target share the held operand registers.
    always_comb begin
        imem_addr   = addr;
        imem_wdata  = wdata;
        dmem_addr   = addr;
        dmem_wdata  = wdata;
        jump_target = addr;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !imem_we && !dmem_we && !dmem_re && !jump_req && rx_ready))
        else $error("AST_RESET_QUIET"); // R10
endmodule

// File: tb/boot_cmd_engine_bench.sv
// Bench: host driver tasks queue the expected transmit bytes, memory writes,
// reads and jumps; monitors pop and compare them as the engine produces them.
module boot_cmd_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic        imem_we, dmem_we, dmem_re, jump_req;
    logic [31:0] imem_addr, imem_wdata, dmem_addr, dmem_wdata, jump_target;
    logic [31:0] dmem_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0]  exp_tx[$];
    logic [63:0] exp_iw[$];
    logic [63:0] exp_dw[$];
    logic [31:0] exp_rd[$];
    logic [31:0] exp_jmp[$];
    logic [31:0] ref_mem[16];
    logic [31:0] dmem_arr[16];

    always #2 clk = ~clk;

    boot_cmd_engine u_boot_cmd_engine (
        .clk(clk), .rst_n(rst_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .jump_req(jump_req), .jump_target(jump_target)
    );

    // Data memory model: registered read, one cycle latency.
    always @(posedge clk) begin
        if (dmem_we) dmem_arr[dmem_addr[3:0]] <= dmem_wdata;
        if (dmem_re) dmem_rdata <= dmem_arr[dmem_addr[3:0]];
    end

    // Transmit ready with periodic stalls.
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) tx_ready <= 1'b1;
        else        tx_ready <= ((cyc % 7) < 4);
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare engine activity against the queued expectations.
    logic       held_v = 1'b0;
    logic [7:0] held_b = 8'h00;
    always @(negedge clk) begin
        if (rst_n) begin
            if (held_v) check(tx_valid && tx_data == held_b, "R8 byte held", {55'd0, tx_valid, tx_data}, {56'd1, held_b});
            held_v = tx_valid && !tx_ready;
            held_b = tx_data;
            if (tx_valid && tx_ready) begin
                check(!rx_ready, "R9 no rx while tx", 64'(rx_ready), 64'd0);
                if (exp_tx.size() == 0) check(0, "R1/R6 unexpected tx byte", 64'(tx_data), 64'd0);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    check(tx_data == e, "R2/R3/R4/R7 tx byte", 64'(tx_data), 64'(e));
                end
            end
            if (imem_we) begin
                if (exp_iw.size() == 0) check(0, "R2 unexpected imem write", {imem_addr, imem_wdata}, 64'd0);
                else begin
                    logic [63:0] e;
                    e = exp_iw.pop_front();
                    check({imem_addr, imem_wdata} == e, "R2 R5 imem write", {imem_addr, imem_wdata}, e);
                end
            end
            if (dmem_we) begin
                if (exp_dw.size() == 0) check(0, "R3 unexpected dmem write", {dmem_addr, dmem_wdata}, 64'd0);
                else begin
                    logic [63:0] e;
                    e = exp_dw.pop_front();
                    check({dmem_addr, dmem_wdata} == e, "R3 R5 dmem write", {dmem_addr, dmem_wdata}, e);
                end
            end
            if (imem_we || dmem_we) check(!(imem_we && dmem_we), "R11 strobes exclusive", 64'({imem_we, dmem_we}), 64'd0);
            if (dmem_re) begin
                if (exp_rd.size() == 0) check(0, "R4 unexpected read", 64'(dmem_addr), 64'd0);
                else begin
                    logic [31:0] e;
                    e = exp_rd.pop_front();
                    check(dmem_addr == e, "R4 read address", 64'(dmem_addr), 64'(e));
                end
            end
            if (jump_req) begin
                if (exp_jmp.size() == 0) check(0, "R6 unexpected jump", 64'(jump_target), 64'd0);
                else begin
                    logic [31:0] e;
                    e = exp_jmp.pop_front();
                    check(jump_target == e && !tx_valid, "R6 jump target", 64'(jump_target), 64'(e));
                end
            end
        end
    end

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    // R5: operand bytes go out most significant first.
    task automatic put_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) put_byte(w[i*8 +: 8]);
    endtask

    task automatic wake();
        exp_tx.push_back(8'h4F);
        put_byte(8'h48);
    endtask

    task automatic cmd_w(input logic [31:0] a, input logic [31:0] d);
        exp_tx.push_back(8'h57);
        exp_iw.push_back({a, d});
        exp_tx.push_back(8'h44);
        put_byte(8'h57); put_word(a); put_word(d);
    endtask

    task automatic cmd_q(input logic [31:0] a, input logic [31:0] d);
        exp_tx.push_back(8'h51);
        exp_dw.push_back({a, d});
        exp_tx.push_back(8'h41);
        ref_mem[a[3:0]] = d;
        put_byte(8'h51); put_word(a); put_word(d);
    endtask

    // R4: reply 0x47, then read data least significant byte first.
    task automatic cmd_t(input logic [31:0] a);
        exp_tx.push_back(8'h47);
        exp_rd.push_back(a);
        for (int i = 0; i < 4; i++) exp_tx.push_back(ref_mem[a[3:0]][i*8 +: 8]);
        put_byte(8'h54); put_word(a);
    endtask

    task automatic cmd_j(input logic [31:0] a);
        exp_jmp.push_back(a);
        put_byte(8'h4A); put_word(a);
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            if (exp_tx.size() == 0 && exp_iw.size() == 0 && exp_dw.size() == 0 &&
                exp_rd.size() == 0 && exp_jmp.size() == 0 && !tx_valid) break;
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: outputs quiet in reset
        check(!tx_valid && !imem_we && !dmem_we && !dmem_re && !jump_req && rx_ready,
              "R10 reset state", 64'({tx_valid, imem_we, dmem_we, dmem_re, jump_req, rx_ready}), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid && rx_ready, "R10 after reset", 64'({tx_valid, rx_ready}), 64'd1);

        // R1: bytes before the wake-up byte are ignored
        put_byte(8'h00); put_byte(8'h57); put_byte(8'h4F); put_byte(8'h54);
        repeat (10) @(negedge clk);
        check(!tx_valid && rx_ready, "R1 ignored before wake", 64'({tx_valid, rx_ready}), 64'd1);
        wake();

        cmd_w(32'h1234_5678, 32'hDEAD_BEEF);            // R2
        exp_tx.push_back(8'h4F); put_byte(8'h52);       // R7 unsupported command
        exp_tx.push_back(8'h4F); put_byte(8'h48);       // R7 wake byte in command mode
        exp_tx.push_back(8'h4F); put_byte(8'hFF);       // R7 arbitrary byte
        cmd_q(32'h0000_0003, 32'hA1B2_C3D4);            // R3
        cmd_q(32'h0000_0005, 32'h00FF_1080);
        cmd_t(32'h0000_0003);                           // R4
        cmd_t(32'h0000_0005);

        // R9: a partial operand waits indefinitely
        exp_tx.push_back(8'h51);
        exp_dw.push_back({32'h0000_0007, 32'h0102_0304});
        ref_mem[7] = 32'h0102_0304;
        put_byte(8'h51); put_byte(8'h00); put_byte(8'h00);
        repeat (60) @(negedge clk);
        check(rx_ready && !dmem_we && exp_dw.size() == 1, "R9 partial operand waits",
              64'({rx_ready, dmem_we}), 64'd2);
        put_byte(8'h00); put_byte(8'h07); put_word(32'h0102_0304);
        exp_tx.push_back(8'h41);
        cmd_t(32'h0000_0007);

        cmd_j(32'h0040_0080);                           // R6
        drain();
        // R6: back to sleep; command bytes are ignored until woken
        put_byte(8'h54); put_byte(8'h57);
        repeat (10) @(negedge clk);
        check(!tx_valid && rx_ready, "R6 idle after jump", 64'({tx_valid, rx_ready}), 64'd1);
        wake();
        cmd_t(32'h0000_0003);
        cmd_w(32'h0000_0100, 32'h0BAD_F00D);
        cmd_j(32'hFFFF_FFFC);
        drain();

        check(exp_tx.size() == 0, "R2/R3/R4/R7 all replies seen", 64'(exp_tx.size()), 64'd0);
        check(exp_iw.size() == 0 && exp_dw.size() == 0, "R2/R3 all writes seen",
              64'(exp_iw.size() + exp_dw.size()), 64'd0);
        check(exp_rd.size() == 0 && exp_jmp.size() == 0, "R4/R6 reads and jumps seen",
              64'(exp_rd.size() + exp_jmp.size()), 64'd0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule